// File: doc/BRIEF.md
# Complementary Three-Phase PWM Generator

This block drives the six switches of a three-phase inverter bridge. A triangle carrier counts up from zero to a programmable peak and back down to zero. Each phase compares the carrier with its own active duty value. The result drives a high-side output and a low-side output. These two outputs are complementary, and an automatic dead gap sits at every switching edge so that the two switches of one leg are never on together.

Software writes duty values into buffer registers through a simple write port. The buffer is copied into the active comparator only when the carrier reaches its peak or its trough, so a half-written set of duties never appears inside a carrier half-period. The full duty range is available, including a constantly-off and a constantly-on leg with no dead-gap glitch. The block also gives out a converter start pulse when the carrier crosses a programmable level, delayed by a programmable number of cycles. It also gives out peak and trough event pulses, and each of these can be masked on its own.

Top module: `cpwm3_top`

## Requirements
- R1: A write is taken on a rising clock edge while `wr_en` is high. Address 0, 1 and 2 are the duty buffers of phase 0, 1 and 2. Address 3 is the carrier peak, address 4 the dead time (low 8 bits), address 5 the converter trigger level, and address 6 the trigger delay (low 8 bits). Address 7 is control: bit 0 is run, bit 1 masks the peak pulse, bit 2 masks the trough pulse.
- R2: While run is set, the carrier goes 0,1,…,peak,peak-1,…,1 and then repeats. One carrier period is 2×peak cycles. While run is clear, the carrier rests at 0.
- R3: The raw compare of a phase is active while the carrier is below the active duty value. For 1 ≤ duty ≤ peak, the raw compare is active for 2×duty−1 cycles of each period.
- R4: Duty 0 keeps the high-side output off and the low-side output on for the whole period. Any duty above peak keeps the high-side output on and the low-side output off for the whole period. In neither case is there a dead gap.
- R5: After every change of the raw compare, both outputs of that phase stay off for dead+1 cycles. Then the output that matches the new raw level turns on. Over a period, high-side on-time is (raw active cycles) − (dead+1), and low-side on-time is (raw inactive cycles) − (dead+1).
- R6: The high-side and low-side outputs of one phase are never on in the same cycle. A side turns on only after a cycle in which the other side was off.
- R7: While running, a written duty buffer reaches the comparator only in a cycle where the carrier equals peak or 0. While stopped, the buffer reaches the comparator at once.
- R8: `irq_peak` is high in each running cycle where the carrier equals peak. `irq_trough` is high in each running cycle where the carrier equals 0. Neither is ever high while stopped.
- R9: Control bit 1 forces `irq_peak` low, and control bit 2 forces `irq_trough` low.
- R10: `adc_trig` is a one-cycle pulse. It comes delay+1 cycles after each running cycle in which the carrier equals the trigger level, on both the rising and the falling pass.
- R11: After reset, all registers are 0, every high-side output is off, every low-side output is on, and `adc_trig`, `irq_peak` and `irq_trough` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 12 | Register write data |
| pwm_p | output | 3 | High-side outputs, one per phase |
| pwm_n | output | 3 | Low-side outputs, one per phase |
| adc_trig | output | 1 | Delayed converter start pulse |
| irq_peak | output | 1 | Carrier-peak event pulse |
| irq_trough | output | 1 | Carrier-trough event pulse |

## Verification
A carrier that turns at the wrong count shows up within one period in two ways. The spacing between peak pulses changes, and every phase's on-time moves by a count the bench can predict. A dead-gap counter that is off by one changes each measured on-time by one cycle per edge. The overlap check catches a missing gap in the very cycle it happens. A duty copy made at the wrong moment shows up as a high-side output that changes within a few cycles of a mid-period write, when it should hold until the next trough. A trigger delay that is wrong shows up in the cycle count from the trough pulse to the converter pulse.

// File: rtl/cpwm3_pkg.sv
// Package: shared register addresses and control-bit positions for the
// complementary three-phase PWM generator. No assumptions beyond a 3-bit
// register address.
package cpwm3_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DUTY0 = 3'd0,
        REG_DUTY1 = 3'd1,
        REG_DUTY2 = 3'd2,
        REG_PEAK  = 3'd3,
        REG_DEAD  = 3'd4,
        REG_TRG   = 3'd5,
        REG_DLY   = 3'd6,
        REG_CTRL  = 3'd7
    } reg_addr_e;

    localparam int CTRL_RUN     = 0;
    localparam int CTRL_MASK_PK = 1;
    localparam int CTRL_MASK_TR = 2;
    localparam int CTRL_W       = 3;
endpackage

// File: rtl/cpwm3_carrier.sv
// Module: triangle carrier. Counts 0 up to peak, then back down to 0, and
// repeats while run is set. Rests at 0 while stopped. Flags the peak and
// trough cycles.
// Assumes peak >= 1 for a meaningful waveform (peak 0 gives a 0/1 toggle).
module cpwm3_carrier #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] peak,
    output logic [CNT_W-1:0] cnt,
    output logic             at_peak,
    output logic             at_trough
);
    logic             up_q;
    logic [CNT_W:0]   cnt_inc;

    // Purpose: next count upward, one bit wider so the turn test never wraps.
    always_comb begin
        cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    end

    // Purpose: step the carrier and turn it round at peak and trough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            up_q <= 1'b1;
        end else if (!run) begin
            cnt  <= '0;
            up_q <= 1'b1;
        end else if (up_q) begin
            cnt <= cnt_inc[CNT_W-1:0];
            if (cnt_inc >= {1'b0, peak}) begin
                up_q <= 1'b0;
            end
        end else begin
            cnt <= cnt - {{(CNT_W-1){1'b0}}, 1'b1};
            if (cnt <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
                up_q <= 1'b1;
            end
        end
    end

    // Purpose: event flags used for the duty copy and the event pulses.
    always_comb begin
        at_peak   = run && (cnt == peak);
        at_trough = run && (cnt == '0);
    end
endmodule

// File: rtl/cpwm3_phase.sv
// Module: one inverter leg. Holds the active duty value, which is copied
// from the buffer when load is high. Compares the carrier with it and
// turns the raw compare into a complementary pair with a dead gap of
// dead+1 cycles after every raw edge.
// Assumes the carrier changes by one per cycle while running.
module cpwm3_phase #(
    parameter int CNT_W = 12,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] duty_buf,
    input  logic [CNT_W-1:0] cnt,
    input  logic [DT_W-1:0]  dead,
    output logic             out_p,
    output logic             out_n
);
    logic [CNT_W-1:0] duty_act;
    logic             raw;
    logic             raw_q;
    logic [DT_W-1:0]  gap_cnt;

    // Purpose: copy the buffered duty into the comparator when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act <= '0;
        end else if (load) begin
            duty_act <= duty_buf;
        end
    end

    // Purpose: raw compare, active while the carrier is below the duty.
    always_comb begin
        raw = (duty_act > cnt);
    end

    // Purpose: blank both sides for dead+1 cycles after each raw edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q   <= 1'b0;
            gap_cnt <= '0;
            out_p   <= 1'b0;
            out_n   <= 1'b1;
        end else begin
            raw_q <= raw;
            if (raw != raw_q) begin
                out_p   <= 1'b0;
                out_n   <= 1'b0;
                gap_cnt <= dead;
            end else if (gap_cnt != '0) begin
                gap_cnt <= gap_cnt - {{(DT_W-1){1'b0}}, 1'b1};
            end else begin
                out_p <= raw;
                out_n <= !raw;
            end
        end
    end
endmodule

// File: rtl/cpwm3_adtrig.sv
// Module: converter start pulse. Arms when the running carrier equals the
// trigger level, counts the delay down, and then gives a one-cycle pulse.
// A new match restarts the delay. Stopping the carrier clears the arm.
module cpwm3_adtrig #(
    parameter int CNT_W = 12,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] level,
    input  logic [DLY_W-1:0] delay,
    output logic             pulse
);
    logic             armed_q;
    logic [DLY_W-1:0] wait_q;
    logic             hit;

    // Purpose: detect the carrier passing the trigger level.
    always_comb begin
        hit   = run && (cnt == level);
        pulse = armed_q && (wait_q == '0);
    end

    // Purpose: arm on a hit, count the delay, and disarm after the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            wait_q  <= '0;
        end else if (!run) begin
            armed_q <= 1'b0;
            wait_q  <= '0;
        end else if (hit) begin
            armed_q <= 1'b1;
            wait_q  <= delay;
        end else if (armed_q) begin
            if (wait_q == '0) begin
                armed_q <= 1'b0;
            end else begin
                wait_q <= wait_q - {{(DLY_W-1){1'b0}}, 1'b1};
            end
        end
    end
endmodule

// File: rtl/cpwm3_top.sv
// Module: complementary three-phase PWM generator top. Holds the
// write-only register file and joins the carrier, one leg per phase and
// the converter trigger. Assumes one write per cycle at most.
module cpwm3_top
    import cpwm3_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DT_W  = 8,
    parameter int DLY_W = 8,
    parameter int NPH   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [NPH-1:0]   pwm_p,
    output logic [NPH-1:0]   pwm_n,
    output logic             adc_trig,
    output logic             irq_peak,
    output logic             irq_trough
);
    logic [CNT_W-1:0]  duty_buf [NPH];
    logic [CNT_W-1:0]  peak_q;
    logic [DT_W-1:0]   dead_q;
    logic [CNT_W-1:0]  trg_q;
    logic [DLY_W-1:0]  dly_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              run_q;
    logic [CNT_W-1:0]  cnt;
    logic              at_peak;
    logic              at_trough;
    logic              duty_load;

    // Purpose: register file written through the simple write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPH; i++) begin
                duty_buf[i] <= '0;
            end
            peak_q <= '0;
            dead_q <= '0;
            trg_q  <= '0;
            dly_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_PEAK: peak_q <= wr_data;
                REG_DEAD: dead_q <= wr_data[DT_W-1:0];
                REG_TRG:  trg_q  <= wr_data;
                REG_DLY:  dly_q  <= wr_data[DLY_W-1:0];
                REG_CTRL: ctrl_q <= wr_data[CTRL_W-1:0];
                default: begin
                    for (int i = 0; i < NPH; i++) begin
                        if (wr_addr == 3'(i)) begin
                            duty_buf[i] <= wr_data;
                        end
                    end
                end
            endcase
        end
    end

    // Purpose: decode control and the moments the duty buffer may be copied.
    always_comb begin
        run_q     = ctrl_q[CTRL_RUN];
        duty_load = !run_q || at_peak || at_trough;
    end

    cpwm3_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .peak     (peak_q),
        .cnt      (cnt),
        .at_peak  (at_peak),
        .at_trough(at_trough)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_leg
        cpwm3_phase #(.CNT_W(CNT_W), .DT_W(DT_W)) u_phase (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (duty_load),
            .duty_buf(duty_buf[g]),
            .cnt     (cnt),
            .dead    (dead_q),
            .out_p   (pwm_p[g]),
            .out_n   (pwm_n[g])
        );
    end

    cpwm3_adtrig #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_adtrig (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run_q),
        .cnt  (cnt),
        .level(trg_q),
        .delay(dly_q),
        .pulse(adc_trig)
    );

    // Purpose: carrier event pulses with individual masks.
    always_comb begin
        irq_peak   = at_peak && !ctrl_q[CTRL_MASK_PK];
        irq_trough = at_trough && !ctrl_q[CTRL_MASK_TR];
    end
endmodule

// File: rtl/cpwm3_chk.sv
// Module: property checker for cpwm3_top, attached with bind. Watches the
// outputs together with the control register.
module cpwm3_chk #(
    parameter int NPH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NPH-1:0] pwm_p,
    input logic [NPH-1:0] pwm_n,
    input logic           adc_trig,
    input logic           irq_peak,
    input logic           irq_trough,
    input logic           run,
    input logic           mask_pk,
    input logic           mask_tr
);
    // R6: the two sides of a leg are never on together
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_p & pwm_n) == '0);

    for (genvar k = 0; k < NPH; k++) begin : g_gap
        // R6: a side turns on only after a cycle with the other side off
        a_r6_gap_before_p: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_p[k]) |-> !$past(pwm_n[k]));
        a_r6_gap_before_n: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_n[k]) |-> !$past(pwm_p[k]));
    end

    // R9: a masked event pulse stays low
    a_r9_peak_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mask_pk |-> !irq_peak);
    a_r9_trough_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mask_tr |-> !irq_trough);

    // R8: no event pulse while the carrier is stopped
    a_r8_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!irq_peak && !irq_trough));

    // R10: the converter start is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> !adc_trig);
endmodule

bind cpwm3_top cpwm3_chk #(.NPH(NPH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_p     (pwm_p),
    .pwm_n     (pwm_n),
    .adc_trig  (adc_trig),
    .irq_peak  (irq_peak),
    .irq_trough(irq_trough),
    .run       (ctrl_q[0]),
    .mask_pk   (ctrl_q[1]),
    .mask_tr   (ctrl_q[2])
);

// File: tb/tb_cpwm3_top.sv
// Bench for cpwm3_top: a vector table of duty/dead settings with expected
// on-times per period, then directed tests for reset, carrier timing,
// converter trigger delay, event masks and the duty double buffer.
module tb_cpwm3_top;
    localparam int PEAK = 20;
    localparam int PER  = 2 * PEAK;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [2:0]  pwm_p;
    logic [2:0]  pwm_n;
    logic        adc_trig;
    logic        irq_peak;
    logic        irq_trough;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // columns: dead, duty0..2, expected p on-time 0..2, expected n on-time 0..2
    localparam int VEC [4][10] = '{
        '{2,  5, 10, 15,   6, 16, 26,  28, 18,  8},
        '{0,  0, 21, 12,   0, 40, 22,  40,  0, 16},
        '{5,  4,  8, 17,   1,  9, 27,  27, 19,  1},
        '{3, 21,  0,  3,  40,  0,  1,   0, 40, 31}
    };

    cpwm3_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pwm_p     (pwm_p),
        .pwm_n     (pwm_n),
        .adc_trig  (adc_trig),
        .irq_peak  (irq_peak),
        .irq_trough(irq_trough)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = 12'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_peak();
        do @(negedge clk); while (!irq_peak);
    endtask

    task automatic wait_trough();
        do @(negedge clk); while (!irq_trough);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int k, np, nt;
        int ph [3];
        int nh [3];
        int ov;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 pwm_p", int'(pwm_p), 0);
        chk("R11 pwm_n", int'(pwm_n), 7);
        chk("R11 quiet", int'({adc_trig, irq_peak, irq_trough}), 0);

        // R1: configure peak, trigger level and delay, then run
        wr(3, PEAK);
        wr(5, 7);
        wr(6, 3);
        wr(7, 1);

        // R3 R4 R5 R6: vector table walk
        for (int v = 0; v < 4; v++) begin
            wr(4, VEC[v][0]);
            for (int i = 0; i < 3; i++) wr(i, VEC[v][1+i]);
            repeat (3) wait_peak();
            for (int i = 0; i < 3; i++) begin ph[i] = 0; nh[i] = 0; end
            ov = 0;
            for (int c = 0; c < PER; c++) begin
                @(negedge clk);
                for (int i = 0; i < 3; i++) begin
                    ph[i] += int'(pwm_p[i]);
                    nh[i] += int'(pwm_n[i]);
                end
                if ((pwm_p & pwm_n) != 0) ov++;
            end
            for (int i = 0; i < 3; i++) begin
                chk($sformatf("R5 vec%0d p%0d on-time", v, i), ph[i], VEC[v][4+i]);
                chk($sformatf("R5 vec%0d n%0d on-time", v, i), nh[i], VEC[v][7+i]);
            end
            chk($sformatf("R6 vec%0d overlap cycles", v), ov, 0);
        end

        // R2: period between peaks and peak-to-trough distance
        wait_peak();
        k = 0;
        do begin @(negedge clk); k++; end while (!irq_peak);
        chk("R2 peak spacing", k, PER);
        k = 0;
        do begin @(negedge clk); k++; end while (!irq_trough);
        chk("R2 peak to trough", k, PEAK);

        // R10: trigger at level 7 with delay 3, both passes
        wait_trough();
        k = 0;
        do begin @(negedge clk); k++; end while (!adc_trig);
        chk("R10 rising pass delay", k, 7 + 3 + 1);
        k = 0;
        do begin @(negedge clk); k++; end while (!adc_trig);
        chk("R10 falling pass spacing", k, 26);
        wr(6, 0);
        wait_trough();
        k = 0;
        do begin @(negedge clk); k++; end while (!adc_trig);
        chk("R10 zero delay", k, 7 + 1);

        // R8 R9: event masks
        wr(7, 3);
        np = 0; nt = 0;
        for (int c = 0; c < 2 * PER; c++) begin
            @(negedge clk);
            np += int'(irq_peak);
            nt += int'(irq_trough);
        end
        chk("R9 peak masked count", np, 0);
        chk("R8 trough count", nt, 2);
        wr(7, 5);
        np = 0; nt = 0;
        for (int c = 0; c < 2 * PER; c++) begin
            @(negedge clk);
            np += int'(irq_peak);
            nt += int'(irq_trough);
        end
        chk("R8 peak count", np, 2);
        chk("R9 trough masked count", nt, 0);

        // R7: duty written mid-period waits for the trough
        wr(7, 1);
        wr(0, 21);
        repeat (3) wait_peak();
        repeat (3) @(negedge clk);
        wr(0, 0);
        k = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            k += int'(pwm_p[0]);
        end
        chk("R7 p0 held until trough", k, 8);
        wait_peak();
        chk("R7 p0 after trough", int'(pwm_p[0]), 0);
        chk("R7 n0 after trough", int'(pwm_n[0]), 1);

        // R7 R8: stopped carrier loads at once and emits no events
        wr(7, 0);
        wr(1, 21);
        np = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            np += int'(irq_peak) + int'(irq_trough) + int'(adc_trig);
        end
        chk("R7 stopped load p1", int'(pwm_p[1]), 1);
        chk("R8 stopped quiet", np, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule